// File: doc/BRIEF.md
# Serial ADC Capture Controller

This block runs a three-wire serial converter: an active-low select, a serial clock and one data line coming back from the converter. A free-running period counter gives a start strobe. On each strobe that finds the block idle, it pulls select low and drives a short acquisition preamble of two clock pulses, timed by their own half-period. It then drives fourteen data clock pulses with a separate half-period. The data line is sampled MSB first at the last system cycle of each low half.

When the word is complete, the upper bit is discarded. The remaining 13 bits are read as a two's-complement code and sign-extended to the output width. The result appears with a one-cycle valid pulse, in the same cycle in which select returns high and the clock settles low.

All three timing values come in on input ports. A value of zero acts as one. A start strobe that arrives while a conversion is in progress is dropped.

Top module: `adc_capture`

## Requirements
- R1: During and after reset, before any start, `adc_cs_n` is 1, `adc_sclk` is 0, `sample_valid` is 0 and `sample` is 0.
- R2: `adc_cs_n` falls only in the cycle after a period strobe, and the first rising edge of `adc_sclk` follows after exactly `acq_half` cycles of select low with the clock low.
- R3: The two acquisition clock pulses are each high for `acq_half` cycles and separated by `acq_half` low cycles.
- R4: Exactly 16 rising edges of `adc_sclk` occur per conversion (2 acquisition + 14 data). Each of the 14 data pulses is high for `clk_half` cycles and low for `clk_half` cycles.
- R5: Each data bit is taken from `adc_dout` in the last cycle of a data low half, and the first bit taken is the most significant bit of the 14-bit word.
- R6: `sample` equals bits 12..0 of the received 14-bit word (bit 13 is ignored) read as two's complement and sign-extended; code 0x1000 gives -4096 and 0x0FFF gives +4095.
- R7: Select stays low for exactly 4*`acq_half` + 28*`clk_half` cycles. In the cycle it rises, `adc_sclk` is 0 and `sample_valid` is 1 for that single cycle.
- R8: The period strobe fires every `period` cycles, so starts are spaced by `period` whenever `period` exceeds the conversion length.
- R9: A strobe that arrives while a conversion runs, including its final cycle, is dropped. Starts are then spaced by the smallest multiple of `period` that is greater than the conversion length.
- R10: A zero in `acq_half`, `clk_half` or `period` behaves as the value 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acq_half | input | TW (16) | Acquisition half-period in system cycles |
| clk_half | input | TW (16) | Data clock half-period in system cycles |
| period | input | TW (16) | System cycles between start strobes |
| adc_dout | input | 1 | Serial data from the converter |
| adc_cs_n | output | 1 | Converter select, active low |
| adc_sclk | output | 1 | Serial clock to the converter |
| sample | output | OUT_W (16) | Sign-extended signed result |
| sample_valid | output | 1 | One-cycle pulse with each new result |

## Verification
The period strobe and the end of a conversion can fall in the same cycle. The bench provokes this by setting `period` equal to the conversion length (for example 32 with both half-periods at 1). It also uses zero-valued settings that collapse to the same length. A correct design drops that strobe, so the bench expects select falls spaced by two periods. With `period` one cycle longer, the spacing must be exactly one period. Both spacings are judged from the measured distance between select falling edges.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;
  localparam int ACQ_PULSES = 2;
  localparam int WORD_BITS  = 14;
  localparam int CODE_BITS  = 13;

  // a programmed zero is taken as one cycle
  function automatic logic [15:0] at_least_one(input logic [15:0] v);
    return (v == '0) ? 16'd1 : v;
  endfunction
endpackage

// File: rtl/adc_period_gen.sv
module adc_period_gen #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] period,
  output logic          tick
);
  import adc_cap_pkg::*;

  logic [TW-1:0] pcnt;
  logic [TW-1:0] span;

  assign span = TW'(at_least_one(16'(period)));
  assign tick = (pcnt >= span - TW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pcnt <= '0;
    else if (tick) pcnt <= '0;
    else           pcnt <= pcnt + TW'(1);
  end

  // R8: after a strobe the counter restarts from zero
  assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (pcnt == '0));
endmodule

// File: rtl/adc_sequencer.sv
module adc_sequencer #(
  parameter int TW         = 16,
  parameter int ACQ_PULSES = 2,
  parameter int WORD_BITS  = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] acq_half,
  input  logic [TW-1:0] clk_half,
  input  logic          start,
  output logic          cs_n,
  output logic          sclk,
  output logic          bit_take,
  output logic          done
);
  import adc_cap_pkg::*;

  localparam int HALVES   = 2 * (ACQ_PULSES + WORD_BITS);
  localparam int ACQ_HALF = 2 * ACQ_PULSES;
  localparam int HW       = $clog2(HALVES + 1);

  logic          busy;
  logic [HW-1:0] hcnt;
  logic [TW-1:0] tcnt;
  logic [TW-1:0] limit;
  logic          in_acq;
  logic          half_end;
  logic          last_half;

  assign in_acq    = (hcnt < HW'(ACQ_HALF));
  assign limit     = in_acq ? TW'(at_least_one(16'(acq_half)))
                            : TW'(at_least_one(16'(clk_half)));
  assign half_end  = busy && (tcnt >= limit - TW'(1));
  assign last_half = (hcnt == HW'(HALVES - 1));
  assign bit_take  = half_end && !in_acq && !hcnt[0];
  assign done      = half_end && last_half;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cs_n <= 1'b1;
      sclk <= 1'b0;
      hcnt <= '0;
      tcnt <= '0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        cs_n <= 1'b0;
        sclk <= 1'b0;
        hcnt <= '0;
        tcnt <= '0;
      end
    end else if (half_end) begin
      tcnt <= '0;
      if (last_half) begin
        busy <= 1'b0;
        cs_n <= 1'b1;
        sclk <= 1'b0;
        hcnt <= '0;
      end else begin
        hcnt <= hcnt + HW'(1);
        sclk <= ~hcnt[0];
      end
    end else begin
      tcnt <= tcnt + TW'(1);
    end
  end

  // R1: an idle sequencer leaves the pins parked
  assert_idle_pins_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cs_n && !sclk));
  // R2: select falls only in response to a strobe
  assert_start_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> $past(start));
  // R4: the clock never runs with select high
  assert_sclk_in_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> !cs_n);
  // R5: data is taken only while the clock is low
  assert_take_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bit_take |-> (!sclk && !cs_n));
  // R9: a strobe during a conversion does not restart it
  assert_drop_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy && !done) |=> !cs_n && (hcnt != '0 || tcnt != '0));
  // R10: the half-phase timer stays below its effective limit
  assert_timer_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (tcnt < limit));
endmodule

// File: rtl/adc_shift_fmt.sv
module adc_shift_fmt #(
  parameter int WORD_BITS = 14,
  parameter int CODE_BITS = 13,
  parameter int OUT_W     = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    din,
  input  logic                    bit_take,
  input  logic                    done,
  output logic signed [OUT_W-1:0] sample,
  output logic                    sample_valid
);
  logic [WORD_BITS-1:0] shreg;

  function automatic logic signed [OUT_W-1:0] widen(input logic [CODE_BITS-1:0] c);
    return {{(OUT_W - CODE_BITS){c[CODE_BITS-1]}}, c};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg        <= '0;
      sample       <= '0;
      sample_valid <= 1'b0;
    end else begin
      if (bit_take) shreg <= {shreg[WORD_BITS-2:0], din};
      sample_valid <= done;
      if (done) sample <= widen(shreg[CODE_BITS-1:0]);
    end
  end

  // R7: the valid strobe lasts a single cycle
  assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |=> !sample_valid);
  // R6: all bits above the code equal its sign bit
  assert_sign_ext_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |-> (sample[OUT_W-1:CODE_BITS-1] == '0 || (&sample[OUT_W-1:CODE_BITS-1])));
endmodule

// File: rtl/adc_capture.sv
module adc_capture #(
  parameter int TW    = 16,
  parameter int OUT_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [TW-1:0]           acq_half,
  input  logic [TW-1:0]           clk_half,
  input  logic [TW-1:0]           period,
  input  logic                    adc_dout,
  output logic                    adc_cs_n,
  output logic                    adc_sclk,
  output logic signed [OUT_W-1:0] sample,
  output logic                    sample_valid
);
  import adc_cap_pkg::*;

  logic start_tick;
  logic bit_take;
  logic frame_done;

  adc_period_gen #(.TW(TW)) u_period (
    .clk(clk), .rst_n(rst_n), .period(period), .tick(start_tick)
  );

  adc_sequencer #(.TW(TW), .ACQ_PULSES(ACQ_PULSES), .WORD_BITS(WORD_BITS)) u_seq (
    .clk(clk), .rst_n(rst_n), .acq_half(acq_half), .clk_half(clk_half),
    .start(start_tick), .cs_n(adc_cs_n), .sclk(adc_sclk),
    .bit_take(bit_take), .done(frame_done)
  );

  adc_shift_fmt #(.WORD_BITS(WORD_BITS), .CODE_BITS(CODE_BITS), .OUT_W(OUT_W)) u_fmt (
    .clk(clk), .rst_n(rst_n), .din(adc_dout), .bit_take(bit_take),
    .done(frame_done), .sample(sample), .sample_valid(sample_valid)
  );

  // R7: a result appears exactly when select is released
  assert_valid_at_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |-> (adc_cs_n && !adc_sclk && !$past(adc_cs_n)));
endmodule

// File: tb/adc_capture_test.sv
`timescale 1ns/1ps
module adc_capture_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] acq_half = 16'd3, clk_half = 16'd2, period = 16'd100;
  logic adc_dout;
  logic adc_cs_n, adc_sclk, sample_valid;
  logic signed [15:0] sample;

  always #10 clk = ~clk;

  adc_capture uut (
    .clk(clk), .rst_n(rst_n), .acq_half(acq_half), .clk_half(clk_half),
    .period(period), .adc_dout(adc_dout), .adc_cs_n(adc_cs_n),
    .adc_sclk(adc_sclk), .sample(sample), .sample_valid(sample_valid)
  );

  int checks = 0, failures = 0;
  int cyc = 0;
  bit timeout = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int nz(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic int code_value(input logic [13:0] w);
    int c = int'(w[12:0]);
    return w[12] ? c - 8192 : c;
  endfunction

  // converter model: one bit per rising edge after the two acquisition pulses
  logic [13:0] next_w = 14'h0;
  logic [13:0] model_w = 14'h0;
  int rises_m = 0;
  always @(negedge adc_cs_n) begin model_w = next_w; rises_m = 0; end
  always @(posedge adc_sclk) rises_m = rises_m + 1;
  assign adc_dout = (rises_m >= 2 && rises_m <= 15) ? model_w[15 - rises_m] : 1'b0;

  // monitor
  bit prev_cs = 1, prev_sclk = 0;
  int last_fall = 0, fall_gap = 0, lowc = 0, firstlow = 0, rises = 0, hirun = 0, runbad = 0;
  int t_a = 1, t_c = 1;
  logic [13:0] t_w = 0;
  int nvalid = 0;
  always @(negedge clk) if (rst_n) begin
    if (prev_cs && !adc_cs_n) begin
      fall_gap = cyc - last_fall; last_fall = cyc;
      lowc = 0; firstlow = 0; rises = 0; hirun = 0; runbad = 0;
      t_w = next_w; t_a = nz(int'(acq_half)); t_c = nz(int'(clk_half));
    end
    if (!adc_cs_n) begin
      lowc++;
      if (!adc_sclk && rises == 0) firstlow++;
    end
    if (adc_sclk && !prev_sclk) rises++;
    if (adc_sclk) hirun++;
    if (!adc_sclk && prev_sclk) begin
      if (hirun != ((rises <= 2) ? t_a : t_c)) runbad++;
      hirun = 0;
    end
    if (sample_valid) begin
      chk(adc_cs_n && !adc_sclk, "R7 pins at release", {adc_cs_n, adc_sclk}, 2);
      chk(lowc == 4*t_a + 28*t_c, "R7 select low length", lowc, 4*t_a + 28*t_c);
      chk(firstlow == t_a, "R2 select to first rise", firstlow, t_a);
      chk(rises == 16, "R4 rising edge count", rises, 16);
      chk(runbad == 0, "R3 R4 high pulse widths", runbad, 0);
      chk(int'(sample) == code_value(t_w), "R5 R6 sample value", int'(sample), code_value(t_w));
      nvalid++;
    end
    prev_cs = adc_cs_n; prev_sclk = adc_sclk;
  end

  logic [13:0] specials [8] = '{14'h1000, 14'h0FFF, 14'h0000, 14'h1FFF,
                                14'h3000, 14'h2FFF, 14'h2AAA, 14'h1555};
  int widx = 0;

  task automatic wait_valid();
    int start_c = cyc;
    do begin
      @(negedge clk);
      if (cyc > 150000) begin timeout = 1; return; end
    end while (!sample_valid);
    widx++;
    next_w = (widx < 8) ? specials[widx] : 14'($urandom);
  endtask

  task automatic run_cfg(input int a, input int c, input int p, input string tag);
    int l, g;
    acq_half = 16'(a); clk_half = 16'(c); period = 16'(p);
    repeat (4) begin
      wait_valid();
      if (timeout) return;
    end
    l = 4*nz(a) + 28*nz(c);
    g = (l / nz(p) + 1) * nz(p);
    chk(fall_gap == g, tag, fall_gap, g);
  endtask

  initial begin
    void'($urandom(32'd1234));
    next_w = specials[0];
    repeat (2) @(negedge clk);
    chk(adc_cs_n == 1 && adc_sclk == 0 && sample_valid == 0, "R1 pins in reset",
        {adc_cs_n, adc_sclk, sample_valid}, 4);
    rst_n = 1'b1;
    @(negedge clk);
    chk(adc_cs_n == 1 && adc_sclk == 0 && sample_valid == 0 && sample == 0,
        "R1 pins after reset", int'(sample), 0);
    run_cfg(3, 2, 100, "R8 start spacing 100");
    if (!timeout) run_cfg(1, 1, 32, "R9 strobe at final cycle dropped");
    if (!timeout) run_cfg(1, 1, 33, "R8 spacing one past length");
    if (!timeout) run_cfg(0, 0, 0, "R10 zero settings");
    if (!timeout) run_cfg(2, 1, 20, "R9 strobes during conversion");
    if (!timeout) run_cfg(40, 25, 1023, "R8 default timing");
    for (int i = 0; i < 6 && !timeout; i++)
      run_cfg(1 + int'($urandom % 6), 1 + int'($urandom % 5),
              20 + int'($urandom % 280), "R9 random spacing");
    if (timeout) chk(0, "watchdog expired", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule